// File: doc/BRIEF.md
# Stereo Volume Attenuator with Soft Mute

This block scales a stereo stream of signed samples by a per-channel volume setting and can fade the pair to silence. Each channel takes an 8-bit level code. Code 255 passes the sample at unity gain. Each lower code adds 0.5 dB of attenuation, so code 1 sits 127 dB down. Code 0 gives silence. When a code changes, the applied level does not jump. It walks one code at a time toward the new setting, at a fixed pace counted in accepted samples.

A single soft-mute input controls a second level that both channels share. Asserting the input walks this level down to silence at a faster pace. Releasing it walks the level back up to unity. The walk turns around from wherever it is when the input changes. The attenuation of the two levels adds in the dB domain.

Samples enter and leave through valid/ready handshakes. The input is accepted when the output register is empty or is being drained in the same cycle. A stalled output holds its data. Every accepted sample pair counts as one sample period for all level walks.

Top module: `dig_atten`

## Requirements
- R1: While `rst_n` is low, each channel's applied level is loaded directly from its code input, with no walk. The shared mute level is loaded as 0 if `smute` is high and as 255 otherwise. After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For an accepted pair, each output equals floor((x·G(n) + 2^16) / 2^17). Here x is the signed input and G(n) = round(2^17 · 10^(−n/40)). The step count n is (255 − channel level) + (255 − mute level), capped at 255, and G(255) = 0. Code 255 with no mute therefore returns the input unchanged.
- R3: A channel whose applied level is 0 outputs 0 for every input.
- R4: When a channel's code differs from its applied level, the level moves one code toward the code every ATT_PACE accepted samples. The first move comes on the ATT_PACE-th accepted sample after the mismatch. The pace counter clears only when the level equals the code.
- R5: With `smute` high, the mute level moves one code toward 0 every MUTE_PACE accepted samples. Once it reaches 0, both outputs are 0.
- R6: If `smute` falls during a fade, the mute level reverses from its present value toward 255 at the same pace. The pace counter is not cleared.
- R7: Left and right levels walk independently, each toward its own code.
- R8: `in_ready` is high exactly when the output is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the outputs hold. Levels advance only on accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high with in_valid |
| in_l | input | DW | Left sample, signed |
| in_r | input | DW | Right sample, signed |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream accepts output pair |
| out_l | output | DW | Scaled left sample |
| out_r | output | DW | Scaled right sample |
| att_l | input | 8 | Left level code, 255 = 0 dB, 0 = silence |
| att_r | input | 8 | Right level code |
| smute | input | 1 | Soft-mute request |

## Verification
The bench builds the block with DW = 16, ATT_PACE = 3 and MUTE_PACE = 2. The short paces bring complete 255-code walks and full fades, with their reversals, within a few hundred samples each. The 16-bit width puts the most positive and most negative inputs under test. All 256 codes are swept on both channels by loading them through reset, and every output is compared against arithmetic gain and rounding computed in the bench.

// File: rtl/dig_atten_pkg.sv
package dig_atten_pkg;
  localparam int LVL_W     = 8;
  localparam int LVL_MAX   = (1 << LVL_W) - 1;
  localparam int GAIN_FRAC = 17;
  localparam int GAIN_W    = GAIN_FRAC + 1;

  // gain for n half-dB steps, unsigned Q1.17; the top step count means silence
  function automatic logic [GAIN_W-1:0] step_gain(int n);
    real v;
    if (n >= LVL_MAX) return '0;
    v = (2.0 ** GAIN_FRAC) * (10.0 ** (-n / 40.0));
    return GAIN_W'($rtoi(v + 0.5));
  endfunction
endpackage

// File: rtl/dig_atten_rom.sv
module dig_atten_rom
  import dig_atten_pkg::*;
(
  input  logic [LVL_W-1:0]  steps,
  output logic [GAIN_W-1:0] gain
);
  localparam int ENTRIES = LVL_MAX + 1;

  logic [GAIN_W-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
    assign tbl[g] = step_gain(g);
  end

  assign gain = tbl[steps];
endmodule

// File: rtl/dig_atten_walk.sv
module dig_atten_walk
  import dig_atten_pkg::*;
#(
  parameter int PACE = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [LVL_W-1:0] tgt,
  output logic [LVL_W-1:0] lvl
);
  localparam int CW = $clog2(PACE + 1);
  localparam logic [CW-1:0] LAST = CW'(PACE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= tgt;
      cnt <= '0;
    end else if (adv) begin
      if (lvl == tgt) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt <= '0;
        lvl <= (tgt > lvl) ? lvl + 1'b1 : lvl - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dig_atten_chan.sv
module dig_atten_chan
  import dig_atten_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [LVL_W-1:0]     lvl_att,
  input  logic [LVL_W-1:0]     lvl_mute,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] y
);
  localparam int PW = DW + GAIN_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GAIN_FRAC - 1);

  logic [LVL_W:0]          sum;
  logic [LVL_W-1:0]        steps;
  logic [GAIN_W-1:0]       gain;
  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    rnd;
  logic                    unused_bits;

  // attenuation of the two levels adds in half-dB steps
  assign sum   = {1'b0, ~lvl_att} + {1'b0, ~lvl_mute};
  assign steps = sum[LVL_W] ? {LVL_W{1'b1}} : sum[LVL_W-1:0];

  dig_atten_rom u_rom (
    .steps (steps),
    .gain  (gain)
  );

  always_comb begin
    prod = PW'(x) * $signed({1'b0, gain});
    rnd  = prod + HALF;
  end

  assign y = rnd[GAIN_FRAC +: DW];
  assign unused_bits = ^{rnd[GAIN_FRAC-1:0], rnd[PW-1:GAIN_FRAC+DW]};
endmodule

// File: rtl/dig_atten.sv
module dig_atten
  import dig_atten_pkg::*;
#(
  parameter int DW        = 32,
  parameter int ATT_PACE  = 29,
  parameter int MUTE_PACE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  input  logic [LVL_W-1:0]     att_l,
  input  logic [LVL_W-1:0]     att_r,
  input  logic                 smute
);
  localparam int NCH = 2;

  logic                    acc;
  logic [LVL_W-1:0]        mute_tgt;
  logic [LVL_W-1:0]        mute_lvl;
  logic [LVL_W-1:0]        code_c [NCH];
  logic [LVL_W-1:0]        lvl_c  [NCH];
  logic signed [DW-1:0]    din    [NCH];
  logic signed [DW-1:0]    dout   [NCH];
  logic [LVL_W-1:0]        lvl_att_l;
  logic [LVL_W-1:0]        lvl_att_r;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign mute_tgt = smute ? '0 : {LVL_W{1'b1}};

  assign code_c[0] = att_l;
  assign code_c[1] = att_r;
  assign din[0]    = in_l;
  assign din[1]    = in_r;
  assign lvl_att_l = lvl_c[0];
  assign lvl_att_r = lvl_c[1];

  dig_atten_walk #(.PACE(MUTE_PACE)) u_mute (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (acc),
    .tgt   (mute_tgt),
    .lvl   (mute_lvl)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dig_atten_walk #(.PACE(ATT_PACE)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (acc),
      .tgt   (code_c[ch]),
      .lvl   (lvl_c[ch])
    );

    dig_atten_chan #(.DW(DW)) u_chan (
      .lvl_att  (lvl_c[ch]),
      .lvl_mute (mute_lvl),
      .x        (din[ch]),
      .y        (dout[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_l     <= dout[0];
      out_r     <= dout[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dig_atten_chk.sv
module dig_atten_chk
  import dig_atten_pkg::*;
#(
  parameter int DW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic [LVL_W-1:0]     att_l,
  input logic [LVL_W-1:0]     lvl_l,
  input logic [LVL_W-1:0]     lvl_r,
  input logic [LVL_W-1:0]     mute_lvl
);
  a_r1_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> lvl_l == $past(att_l));

  a_r3_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && lvl_l == '0) |=> out_l == '0);

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_l == $past(lvl_l)) || (lvl_l == $past(lvl_l) + 8'd1) || (lvl_l == $past(lvl_l) - 8'd1));

  a_r4_toward_code: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_l != $past(lvl_l)) |-> ((lvl_l > $past(lvl_l)) == ($past(att_l) > $past(lvl_l))));

  a_r5_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mute_lvl == '0) |=> (out_l == '0 && out_r == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_l) && $stable(out_r)));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(lvl_l) && $stable(lvl_r) && $stable(mute_lvl)));
endmodule

bind dig_atten dig_atten_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_l     (out_l),
  .out_r     (out_r),
  .att_l     (att_l),
  .lvl_l     (lvl_att_l),
  .lvl_r     (lvl_att_r),
  .mute_lvl  (mute_lvl)
);

// File: tb/test_dig_atten.sv
`timescale 1ns/1ps
module test_dig_atten;
  localparam int DW = 16;
  localparam int AP = 3;
  localparam int MP = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_l = '0;
  logic signed [DW-1:0] in_r = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic signed [DW-1:0] out_l;
  logic signed [DW-1:0] out_r;
  logic [7:0]           att_l = 8'hFF;
  logic [7:0]           att_r = 8'hFF;
  logic                 smute = 1'b0;

  dig_atten #(.DW(DW), .ATT_PACE(AP), .MUTE_PACE(MP)) i_dig_atten (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_l(in_l), .in_r(in_r), .out_valid(out_valid), .out_ready(out_ready),
    .out_l(out_l), .out_r(out_r), .att_l(att_l), .att_r(att_r), .smute(smute)
  );

  int total = 0;
  int bad   = 0;
  int m_lvl [2];
  int m_cnt [2];
  int m_mlvl;
  int m_mcnt;

  function automatic longint gref(int n);
    if (n >= 255) return 0;
    return longint'($rtoi(131072.0 * (10.0 ** (-n / 40.0)) + 0.5));
  endfunction

  function automatic longint expv(longint x, int lvl, int mlvl);
    int n;
    n = (255 - lvl) + (255 - mlvl);
    if (n > 255) n = 255;
    return (x * gref(n) + 65536) >>> 17;
  endfunction

  function automatic logic signed [DW-1:0] pat(int i, int ch);
    return DW'(i * 7919 + ch * 12345 + 77);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic walk(inout int lvl, inout int cnt, input int tgt, input int pace);
    if (lvl == tgt) cnt = 0;
    else if (cnt == pace - 1) begin
      cnt = 0;
      lvl = lvl + ((tgt > lvl) ? 1 : -1);
    end else cnt++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_lvl[0] = int'(att_l);
    m_lvl[1] = int'(att_r);
    m_cnt[0] = 0;
    m_cnt[1] = 0;
    m_mlvl = smute ? 0 : 255;
    m_mcnt = 0;
  endtask

  task automatic advance_model();
    walk(m_lvl[0], m_cnt[0], int'(att_l), AP);
    walk(m_lvl[1], m_cnt[1], int'(att_r), AP);
    walk(m_mlvl, m_mcnt, smute ? 0 : 255, MP);
  endtask

  // called at a negedge with out_ready high
  task automatic send(logic signed [DW-1:0] l, logic signed [DW-1:0] r, string req);
    longint el, er;
    in_l = l;
    in_r = r;
    in_valid = 1'b1;
    el = expv(longint'(l), m_lvl[0], m_mlvl);
    er = expv(longint'(r), m_lvl[1], m_mlvl);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, longint'(out_valid), 1);
    chk(req, longint'(out_l), el);
    chk(req, longint'(out_r), er);
    advance_model();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // every code on both channels, loaded through reset (R1, R2, R3, R7)
    for (int c = 0; c < 256; c++) begin
      att_l = 8'(c);
      att_r = 8'(255 - c);
      smute = 1'b0;
      do_reset();
      chk("R1 out_valid", longint'(out_valid), 0);
      chk("R1 in_ready", longint'(in_ready), 1);
      send(16'sh7FFF, -16'sh8000, "R1");
      send(-16'sh8000, 16'sh7FFF, (c == 0) ? "R3" : "R2");
      send(pat(c, 0), pat(c, 1), "R2 R7");
    end

    // code walks, down then back up, channels apart (R4, R7)
    att_l = 8'hFF;
    att_r = 8'hFF;
    do_reset();
    att_l = 8'h80;
    att_r = 8'hF0;
    for (int i = 0; i < 450; i++) send(pat(i, 0), pat(i, 1), "R4");
    att_l = 8'hC0;
    att_r = 8'h00;
    for (int i = 0; i < 250; i++) send(pat(i, 2), pat(i, 3), "R7");
    att_l = 8'hFF;
    att_r = 8'hFF;
    for (int i = 0; i < 800; i++) send(pat(i, 4), pat(i, 5), "R4");

    // fade, release mid-way, fade fully (R5, R6)
    smute = 1'b1;
    for (int i = 0; i < 300; i++) send(pat(i, 6), pat(i, 7), "R5");
    smute = 1'b0;
    for (int i = 0; i < 200; i++) send(pat(i, 8), pat(i, 9), "R6");
    smute = 1'b1;
    for (int i = 0; i < 600; i++) send(pat(i, 10), pat(i, 11), "R5");
    send(16'sh7FFF, -16'sh8000, "R5");
    chk("R5 silent left", longint'(out_l), 0);
    chk("R5 silent right", longint'(out_r), 0);
    smute = 1'b0;
    for (int i = 0; i < 100; i++) send(pat(i, 12), pat(i, 13), "R6");

    // reset while muted loads silence directly (R1)
    smute = 1'b1;
    do_reset();
    send(16'sh4000, 16'sh4000, "R1");
    chk("R1 muted at reset", longint'(out_l), 0);
    smute = 1'b0;
    do_reset();

    // back-pressure (R8)
    att_l = 8'hF0;
    begin
      longint ea, eb;
      in_l = 16'sh1234;
      in_r = -16'sh1234;
      in_valid = 1'b1;
      ea = expv(longint'(in_l), m_lvl[0], m_mlvl);
      @(negedge clk);
      advance_model();
      in_l = 16'sh7000;
      in_r = 16'sh0100;
      out_ready = 1'b0;
      eb = expv(longint'(in_l), m_lvl[0], m_mlvl);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R8 in_ready low", longint'(in_ready), 0);
        chk("R8 held", longint'(out_l), ea);
        chk("R8 valid held", longint'(out_valid), 1);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 after stall", longint'(out_l), eb);
      advance_model();
      @(negedge clk);
      chk("R8 drained", longint'(out_valid), 0);
    end
    for (int i = 0; i < 20; i++) send(pat(i, 14), pat(i, 15), "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule